// File: doc/BRIEF.md
# Processor Bus to JTAG Bridge

This block sits on an embedded processor's parallel bus and gives software direct, bit-level control of a JTAG chain through one decoded bus address. A qualified bus write loads three registered outputs that drive the chain's TDI, TMS and TCK lines. Software clocks the chain by writing TCK high and then low through this register. A qualified read returns the chain's TDO together with the present contents of the three registers, so software can confirm what it last wrote.

A select input hands the chain pins to an external download cable instead of the processor. That input passes through a synchronizer before it steers a 3-bit, two-way multiplexer. The chain's TDO is always forwarded to the cable side. The read data port and its output enable feed the pad ring's tri-state buffer, so the block itself contains no internal tri-state nets.

Top module: `pbus_jtag_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, the TDI, TMS and TCK registers clear to 0, and a qualified write during reset does not load them. After reset the chain outputs are 0 and `bus_oe` is low.
- R2: A qualified write sets the registers at the next rising clock edge. A qualified write means `bus_strobe`=1, `bus_rnw`=0 and `bus_addr` equal to `CHAIN_ADDR`. Data bit 0 goes to the TDI register, bit 1 to the TMS register and bit 2 to the TCK register.
- R3: During a qualified read (`bus_strobe`=1, `bus_rnw`=1, address match), `bus_oe` is 1 in the same cycle. `bus_rdata` then carries bit 3 = `chain_tdo`, bit 2 = TCK register, bit 1 = TMS register and bit 0 = TDI register.
- R4: When no qualified read is present, `bus_oe` is 0 and `bus_rdata` is 0.
- R5: A write to any other address, or a write with `bus_strobe`=0, leaves all three registers unchanged.
- R6: A qualified read leaves all three registers unchanged.
- R7: When `cable_sel` is 0 after synchronization, the chain outputs follow the registers. When it is 1, they follow `cable_tdi`, `cable_tms` and `cable_tck`. A change on `cable_sel` reaches the multiplexer on the `SYNC_STAGES`-th rising edge after it is applied.
- R8: Switching `cable_sel` either way does not change the stored register values. They still read back and drive the chain again once the processor is reselected.
- R9: `cable_tdo` equals `chain_tdo` at all times.
- R10: When software paces its TCK writes at least 50 ns apart, every TCK high phase and low phase on `chain_tck` lasts at least 50 ns, and every TCK period lasts at least 100 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may be shared with the processor |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Processor address bus |
| bus_strobe | input | 1 | Address valid / access strobe, active high |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | DATA_W | Write data from the processor |
| bus_rdata | output | DATA_W | Read data toward the pad tri-state buffer |
| bus_oe | output | 1 | Enable for the pad tri-state buffer |
| cable_sel | input | 1 | 1 = download cable owns the chain (asynchronous) |
| cable_tdi | input | 1 | TDI from the download cable |
| cable_tms | input | 1 | TMS from the download cable |
| cable_tck | input | 1 | TCK from the download cable |
| cable_tdo | output | 1 | Chain TDO returned to the cable |
| chain_tdi | output | 1 | TDI to the JTAG chain |
| chain_tms | output | 1 | TMS to the JTAG chain |
| chain_tck | output | 1 | TCK to the JTAG chain |
| chain_tdo | input | 1 | TDO from the last device of the chain |

## Verification
The assertions assume that the bus inputs are stable around each rising clock edge, which makes each access one clean cycle. They also assume that `rst_n` is low at the first clock edge. The bench meets both conditions by driving every bus, cable and select input only at falling edges, with reset low from time zero. The cable inputs and `cable_tdo` are treated as asynchronous pass-through paths. `cable_sel` is changed only while the bench is not checking the cycles in which the synchronizer is switching. The TCK timing checks assume that software waits between TCK writes, and the bench's TCK phase enforces this by leaving at least 13 idle clocks between toggles.

// File: rtl/bjb_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the bus-to-JTAG bridge.
// Assumes: the bit order of jtag_bits_t matches the write-data field order (bit 0 = TDI).
package bjb_pkg;

    // Register image of the three driven chain lines; bit 0 TDI, bit 1 TMS, bit 2 TCK.
    typedef struct packed {
        logic tck;
        logic tms;
        logic tdi;
    } jtag_bits_t;

    localparam int JTAG_BITS = $bits(jtag_bits_t);

endpackage

// File: rtl/bjb_decode.sv
`timescale 1ns/1ps
// Module: bjb_decode
// Qualifies a bus access against the single chain address and splits it into read and write hits.
// Assumes: bus signals are stable around the sampling clock edge; strobe is active high.
module bjb_decode #(
    parameter int               ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] CHAIN_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strobe,
    input  logic              bus_rnw,
    output logic              rd_hit,
    output logic              wr_hit
);

    logic addr_match;

    // Compare the full address and gate it with strobe and direction.
    always_comb begin
        addr_match = (bus_addr == CHAIN_ADDR);
        rd_hit     = bus_strobe && addr_match && bus_rnw;
        wr_hit     = bus_strobe && addr_match && !bus_rnw;
    end

endmodule

// File: rtl/bjb_regs.sv
`timescale 1ns/1ps
// Module: bjb_regs
// Holds the TDI/TMS/TCK output flip-flops, loaded in one clock by a write hit.
// Assumes: reset is synchronous and active low; reset wins over a simultaneous write.
module bjb_regs
    import bjb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  jtag_bits_t load_bits,
    output jtag_bits_t q
);

    // Clear on reset, otherwise capture the write bits when loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_bits;
        end
    end

endmodule

// File: rtl/bjb_sync.sv
`timescale 1ns/1ps
// Module: bjb_sync
// Flip-flop chain that brings an asynchronous level into the clock domain.
// Assumes: STAGES >= 1; the output reset value is 0 (processor owns the chain).
module bjb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stage;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= 1'b0;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                // Later stages pass the level down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[i] <= 1'b0;
                    else        stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/bjb_chain_mux.sv
`timescale 1ns/1ps
// Module: bjb_chain_mux
// Per-bit two-way selector that picks the chain drivers from the cable or the registers.
// Assumes: sel is already synchronous to the system clock.
module bjb_chain_mux #(
    parameter int WIDTH = 3
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] from_regs,
    input  logic [WIDTH-1:0] from_cable,
    output logic [WIDTH-1:0] to_chain
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            // One selector per chain line.
            assign to_chain[b] = sel ? from_cable[b] : from_regs[b];
        end
    endgenerate

endmodule

// File: rtl/pbus_jtag_bridge.sv
`timescale 1ns/1ps
// Module: pbus_jtag_bridge (top)
// Lets a processor bit-bang a JTAG chain through one bus address, with readback,
// and shares the chain pins with a download cable under a synchronized select.
// Assumes: DATA_W >= 4; bus_rdata/bus_oe feed a tri-state pad buffer outside this block.
module pbus_jtag_bridge
    import bjb_pkg::*;
#(
    parameter int                ADDR_W      = 20,
    parameter int                DATA_W      = 4,
    parameter logic [ADDR_W-1:0] CHAIN_ADDR  = 20'hC0010,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strobe,
    input  logic              bus_rnw,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe,
    input  logic              cable_sel,
    input  logic              cable_tdi,
    input  logic              cable_tms,
    input  logic              cable_tck,
    output logic              cable_tdo,
    output logic              chain_tdi,
    output logic              chain_tms,
    output logic              chain_tck,
    input  logic              chain_tdo
);

    localparam int TDO_BIT = JTAG_BITS;

    logic       rd_hit;
    logic       wr_hit;
    logic       sel_q;
    jtag_bits_t jtag_q;
    jtag_bits_t wr_bits;
    jtag_bits_t cable_bits;
    jtag_bits_t chain_bits;

    bjb_decode #(
        .ADDR_W     (ADDR_W),
        .CHAIN_ADDR (CHAIN_ADDR)
    ) u_decode (
        .bus_addr   (bus_addr),
        .bus_strobe (bus_strobe),
        .bus_rnw    (bus_rnw),
        .rd_hit     (rd_hit),
        .wr_hit     (wr_hit)
    );

    // Slice the write field into the register image.
    assign wr_bits = jtag_bits_t'(bus_wdata[JTAG_BITS-1:0]);

    bjb_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_hit),
        .load_bits (wr_bits),
        .q         (jtag_q)
    );

    bjb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sel_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cable_sel),
        .q     (sel_q)
    );

    // Gather the cable lines in register order.
    assign cable_bits = '{tck: cable_tck, tms: cable_tms, tdi: cable_tdi};

    bjb_chain_mux #(
        .WIDTH (JTAG_BITS)
    ) u_mux (
        .sel        (sel_q),
        .from_regs  (jtag_q),
        .from_cable (cable_bits),
        .to_chain   (chain_bits)
    );

    assign chain_tdi = chain_bits.tdi;
    assign chain_tms = chain_bits.tms;
    assign chain_tck = chain_bits.tck;
    assign cable_tdo = chain_tdo;

    // Build the readback word and enable the pad driver only on a read hit.
    always_comb begin
        bus_rdata = '0;
        bus_oe    = rd_hit;
        if (rd_hit) begin
            bus_rdata[JTAG_BITS-1:0] = jtag_q;
            bus_rdata[TDO_BIT]       = chain_tdo;
        end
    end

endmodule

// File: rtl/bjb_checker.sv
`timescale 1ns/1ps
// Module: bjb_checker
// Property checks for pbus_jtag_bridge, attached by bind below.
// Assumes: rst_n is low at the first clock edge; bus inputs are stable around edges.
module bjb_checker #(
    parameter int                ADDR_W     = 20,
    parameter int                DATA_W     = 4,
    parameter logic [ADDR_W-1:0] CHAIN_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_strobe,
    input logic              bus_rnw,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_oe,
    input logic              cable_tdi,
    input logic              cable_tms,
    input logic              cable_tck,
    input logic              cable_tdo,
    input logic              chain_tdi,
    input logic              chain_tms,
    input logic              chain_tck,
    input logic              chain_tdo,
    input logic              sel_q,
    input logic [2:0]        regs_q
);

    logic chk_rd;
    logic chk_wr;

    // Independent view of the bus qualification, taken from the ports.
    always_comb begin
        chk_rd = bus_strobe && bus_rnw && (bus_addr == CHAIN_ADDR);
        chk_wr = bus_strobe && !bus_rnw && (bus_addr == CHAIN_ADDR);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (regs_q == 3'b000));

    p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_wr |=> (regs_q == $past(bus_wdata[2:0])));

    p_read_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_rd |-> (bus_oe && bus_rdata[3:0] == {chain_tdo, regs_q}));

    p_idle_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_rd |-> (!bus_oe && bus_rdata == '0));

    p_hold_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_wr |=> $stable(regs_q));

    p_cable_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |-> ({chain_tck, chain_tms, chain_tdi} == {cable_tck, cable_tms, cable_tdi}));

    p_regs_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> ({chain_tck, chain_tms, chain_tdi} == regs_q));

    p_tdo_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cable_tdo == chain_tdo);

endmodule

bind pbus_jtag_bridge bjb_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CHAIN_ADDR (CHAIN_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_strobe (bus_strobe),
    .bus_rnw    (bus_rnw),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_oe     (bus_oe),
    .cable_tdi  (cable_tdi),
    .cable_tms  (cable_tms),
    .cable_tck  (cable_tck),
    .cable_tdo  (cable_tdo),
    .chain_tdi  (chain_tdi),
    .chain_tms  (chain_tms),
    .chain_tck  (chain_tck),
    .chain_tdo  (chain_tdo),
    .sel_q      (sel_q),
    .regs_q     (jtag_q)
);

// File: tb/pbus_jtag_bridge_tb.sv
`timescale 1ns/1ps
// Bench for pbus_jtag_bridge: directed corners plus seeded random bus traffic.
module pbus_jtag_bridge_tb;

    localparam int          ADDR_W = 20;
    localparam int          DATA_W = 4;
    localparam logic [19:0] CADDR  = 20'hC0010;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_strobe = 1'b0;
    logic              bus_rnw = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_oe;
    logic              cable_sel = 1'b0;
    logic              cable_tdi = 1'b0;
    logic              cable_tms = 1'b0;
    logic              cable_tck = 1'b0;
    logic              cable_tdo;
    logic              chain_tdi;
    logic              chain_tms;
    logic              chain_tck;
    logic              chain_tdo = 1'b0;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;
    bit   tck_watch = 1'b0;
    logic [2:0] exp_q = 3'b000;
    realtime t_rise = -1.0;
    realtime t_fall = -1.0;

    always #2 clk = ~clk;   // 250 MHz

    pbus_jtag_bridge #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CHAIN_ADDR (CADDR)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_strobe (bus_strobe),
        .bus_rnw    (bus_rnw),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_oe     (bus_oe),
        .cable_sel  (cable_sel),
        .cable_tdi  (cable_tdi),
        .cable_tms  (cable_tms),
        .cable_tck  (cable_tck),
        .cable_tdo  (cable_tdo),
        .chain_tdi  (chain_tdi),
        .chain_tms  (chain_tms),
        .chain_tck  (chain_tck),
        .chain_tdo  (chain_tdo)
    );

    // Expected readback word: bit 3 TDO, bits 2..0 TCK/TMS/TDI registers.
    function automatic logic [3:0] exp_read(input logic [2:0] q, input logic tdo);
        return {tdo, q};
    endfunction

    // Whether an access counts as a qualified write.
    function automatic bit is_wr_hit(input logic [19:0] a, input logic s, input logic rnw);
        return s && !rnw && (a == CADDR);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Chain outputs must equal the register model (processor selected).
    task automatic chk_chain(input string tag);
        chk({chain_tck, chain_tms, chain_tdi} == exp_q, tag,
            int'({chain_tck, chain_tms, chain_tdi}), int'(exp_q));
        chk(cable_tdo == chain_tdo, "R9 cable_tdo follows chain_tdo",
            int'(cable_tdo), int'(chain_tdo));
    endtask

    // One bus access: drive at a falling edge, check read side, then check registers.
    task automatic bus_op(input logic [19:0] a, input logic s, input logic rnw,
                          input logic [3:0] wd, input logic tdo);
        bit rd;
        @(negedge clk);
        bus_addr = a; bus_strobe = s; bus_rnw = rnw; bus_wdata = wd; chain_tdo = tdo;
        rd = s && rnw && (a == CADDR);
        #1;
        if (rd) begin
            chk(bus_oe == 1'b1, "R3 oe on read", int'(bus_oe), 1);
            chk(bus_rdata == exp_read(exp_q, tdo), "R3 read word",
                int'(bus_rdata), int'(exp_read(exp_q, tdo)));
        end else begin
            chk(bus_oe == 1'b0 && bus_rdata == 4'h0, "R4 bus idle",
                int'({bus_oe, bus_rdata}), 0);
        end
        @(negedge clk);
        if (is_wr_hit(a, s, rnw)) exp_q = wd[2:0];
        bus_strobe = 1'b0;
        if (is_wr_hit(a, s, rnw))  chk_chain("R2 write loads TDI/TMS/TCK");
        else if (rd)               chk_chain("R6 read keeps registers");
        else                       chk_chain("R5 non-hit keeps registers");
    endtask

    // TCK phase timing monitor.
    always @(posedge chain_tck) begin
        if (tck_watch) begin
            if (t_fall >= 0.0)
                chk(($realtime - t_fall) >= 50.0, "R10 TCK low time",
                    $rtoi($realtime - t_fall), 50);
            if (t_rise >= 0.0)
                chk(($realtime - t_rise) >= 100.0, "R10 TCK period",
                    $rtoi($realtime - t_rise), 100);
            t_rise = $realtime;
        end
    end

    always @(negedge chain_tck) begin
        if (tck_watch) begin
            if (t_rise >= 0.0)
                chk(($realtime - t_rise) >= 50.0, "R10 TCK high time",
                    $rtoi($realtime - t_rise), 50);
            t_fall = $realtime;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);

        // R1: qualified write during reset must not load.
        bus_addr = CADDR; bus_strobe = 1'b1; bus_rnw = 1'b0; bus_wdata = 4'h7;
        repeat (4) @(negedge clk);
        bus_strobe = 1'b0;
        #1;
        chk({chain_tck, chain_tms, chain_tdi} == 3'b000, "R1 reset clears registers",
            int'({chain_tck, chain_tms, chain_tdi}), 0);
        chk(bus_oe == 1'b0, "R1 bus disabled in reset", int'(bus_oe), 0);
        rst_n = 1'b1;

        // R2: each bit position separately, then all.
        bus_op(CADDR, 1'b1, 1'b0, 4'b0001, 1'b0);
        bus_op(CADDR, 1'b1, 1'b0, 4'b0010, 1'b1);
        bus_op(CADDR, 1'b1, 1'b0, 4'b0100, 1'b0);
        bus_op(CADDR, 1'b1, 1'b0, 4'b1111, 1'b1);
        // R3: read both TDO values.
        bus_op(CADDR, 1'b1, 1'b1, 4'h0, 1'b1);
        bus_op(CADDR, 1'b1, 1'b1, 4'h0, 1'b0);
        // R5: address off by the top bit, off by the bottom bit, and no strobe.
        bus_op(CADDR ^ 20'h80000, 1'b1, 1'b0, 4'h0, 1'b0);
        bus_op(CADDR ^ 20'h00001, 1'b1, 1'b0, 4'h2, 1'b0);
        bus_op(CADDR, 1'b0, 1'b0, 4'h0, 1'b0);
        // R4: read of wrong address and read without strobe.
        bus_op(CADDR ^ 20'h00100, 1'b1, 1'b1, 4'h0, 1'b1);
        bus_op(CADDR, 1'b0, 1'b1, 4'h0, 1'b1);

        // R7/R8: hand the chain to the cable and back.
        bus_op(CADDR, 1'b1, 1'b0, 4'b0101, 1'b0);
        @(negedge clk);
        cable_sel = 1'b1; cable_tdi = 1'b0; cable_tms = 1'b1; cable_tck = 1'b0;
        @(negedge clk);
        chk({chain_tck, chain_tms, chain_tdi} == exp_q, "R7 select latency stage 1",
            int'({chain_tck, chain_tms, chain_tdi}), int'(exp_q));
        @(negedge clk);
        chk({chain_tck, chain_tms, chain_tdi} == 3'b010, "R7 cable drives chain",
            int'({chain_tck, chain_tms, chain_tdi}), 2);
        cable_tdi = 1'b1; cable_tms = 1'b0; cable_tck = 1'b1;
        #1;
        chk({chain_tck, chain_tms, chain_tdi} == 3'b101, "R7 cable pass-through",
            int'({chain_tck, chain_tms, chain_tdi}), 5);
        @(negedge clk);
        bus_addr = CADDR; bus_strobe = 1'b1; bus_rnw = 1'b1; chain_tdo = 1'b1;
        #1;
        chk(bus_rdata == exp_read(exp_q, 1'b1), "R8 registers kept under cable",
            int'(bus_rdata), int'(exp_read(exp_q, 1'b1)));
        @(negedge clk);
        bus_strobe = 1'b0;
        cable_sel = 1'b0;
        repeat (2) @(negedge clk);
        chk_chain("R8 registers drive chain after reselect");

        // R10: software-paced TCK toggling.
        tck_watch = 1'b1;
        for (int k = 0; k < 12; k++) begin
            bus_op(CADDR, 1'b1, 1'b0, {1'b0, k[0] ? 3'b100 : 3'b000} | 4'b0010, 1'b0);
            repeat (12) @(negedge clk);
        end
        tck_watch = 1'b0;

        // Seeded random traffic, processor selected.
        for (int n = 0; n < 400; n++) begin
            logic [19:0] a;
            a = 20'($urandom);
            if ($urandom_range(0, 1) == 0) a = CADDR;
            else if (a == CADDR) a = a ^ 20'h1;
            bus_op(a, 1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom));
        end

        // R1: reset in mid run.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_q = 3'b000;
        chk_chain("R1 mid-run reset clears");

        finish_run();
    end

endmodule